// File: doc/BRIEF.md
# Ethernet Station Address Match Table

This block keeps a small table of exact-match station addresses for an Ethernet receiver. Software loads each entry through a plain register port as two 32-bit accesses: a low word with the first four address bytes and a high word with the last two bytes and an enable flag. The receive path presents a 48-bit destination address with a one-cycle strobe. One clock later the block reports whether any enabled entry equals it, and which one.

Addresses are stored byte-reversed. The first byte on the wire sits in the least significant byte of the low word. The compare logic works from a separate copy of each entry. That copy is refreshed only when the high word is written, so a half-written entry never takes part in matching. After reset, entry 0 holds the station address given as a parameter and every other entry is zero.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, entry 0 holds the parameter `STATION_ADDR` and is enabled when that address is non-zero. Every other entry reads back as zero and is disabled.
- R2: The low word of an entry (register offset bit 0 = 0) holds address byte 0 in bits 7:0, byte 1 in bits 15:8, byte 2 in bits 23:16 and byte 3 in bits 31:24. It reads back as written.
- R3: The high word (offset bit 0 = 1) holds byte 4 in bits 7:0, byte 5 in bits 15:8 and the enable flag in bit 31. Bits 30:16 always read back as zero.
- R4: An entry becomes enabled only when its high word is written with bit 31 set and the resulting 48-bit address is non-zero. A write with the flag set for an all-zero address leaves bit 31 reading 0.
- R5: A write to the low word alone does not change how the entry matches. The new bytes take part in compares only after the next high-word write to that entry.
- R6: `res_valid` is high in exactly the cycle after a cycle with `da_valid` high. `res_hit` and `res_idx` are valid in that cycle.
- R7: An enabled entry whose address equals `da_addr` gives `res_hit`=1 and `res_idx` = its index. If no enabled entry is equal, the result is `res_hit`=0 and `res_idx`=0.
- R8: When several enabled entries match, `res_idx` is the lowest matching index.
- R9: A disabled entry never matches, even when its stored bytes equal `da_addr`.
- R10: `da_addr[47:40]` is byte 0, the first byte on the wire, and `da_addr[7:0]` is byte 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+1 | Bit 0 selects high (1) or low (0) word; upper bits select the entry |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| da_valid | input | 1 | Destination address strobe |
| da_addr | input | 48 | Destination address, byte 0 in bits 47:40 |
| res_valid | output | 1 | Match result valid |
| res_hit | output | 1 | Some enabled entry matched |
| res_idx | output | IDX_W | Lowest matching entry index |

## Verification
Lookups are tried with the station address, with an address loaded into two enabled entries and one disabled entry, with a byte-reversed copy of a stored address, with addresses one bit away from stored ones, and with the all-zero address. Together these separate a correct priority from a highest-index winner, and a real byte order from a mirrored one. They also show whether a disabled entry or an empty slot is wrongly counted as a match. Directed sequences cover a lone low-word write followed by lookups of both the old and the new address, a zero address written with the flag set, and reserved-bit readback. These expose a compare that follows the staged low word, and a flag that ignores the non-zero rule.

// File: rtl/raf_pkg.sv
package raf_pkg;

    localparam int MAC_W  = 48;
    localparam int WORD_W = 32;
    localparam int HI_W   = 16;

    typedef struct packed {
        logic [WORD_W-1:0] lo;
        logic [HI_W-1:0]   hi;
        logic [MAC_W-1:0]  cmp;
        logic              vld;
    } entry_t;

    // Assemble a network-order address (byte 0 in the top byte) from a word pair
    function automatic logic [MAC_W-1:0] words_to_mac(input logic [WORD_W-1:0] lo,
                                                      input logic [HI_W-1:0]   hi);
        return {lo[7:0], lo[15:8], lo[23:16], lo[31:24], hi[7:0], hi[15:8]};
    endfunction

    function automatic logic [WORD_W-1:0] mac_to_lo(input logic [MAC_W-1:0] mac);
        return {mac[23:16], mac[31:24], mac[39:32], mac[47:40]};
    endfunction

    function automatic logic [HI_W-1:0] mac_to_hi(input logic [MAC_W-1:0] mac);
        return {mac[7:0], mac[15:8]};
    endfunction

endpackage

// File: rtl/raf_entry_bank.sv
module raf_entry_bank
    import raf_pkg::*;
#(
    parameter int               NUM_ENTRIES  = 16,
    parameter logic [MAC_W-1:0] STATION_ADDR = 48'h02005E102030,
    localparam int              IDX_W        = $clog2(NUM_ENTRIES)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic                             wr_hi,
    input  logic [WORD_W-1:0]                wr_data,
    input  logic [IDX_W-1:0]                 rd_idx,
    input  logic                             rd_hi,
    output logic [WORD_W-1:0]                rd_data,
    output logic [NUM_ENTRIES-1:0][MAC_W-1:0] cmp_addr,
    output logic [NUM_ENTRIES-1:0]           cmp_vld
);

    localparam int RSV_W = WORD_W - HI_W - 1;

    entry_t ent_d [NUM_ENTRIES];
    entry_t ent_q [NUM_ENTRIES];

    logic [MAC_W-1:0] new_mac;

    always_comb begin
        for (int i = 0; i < NUM_ENTRIES; i++) ent_d[i] = ent_q[i];
        new_mac = words_to_mac(ent_q[wr_idx].lo, wr_data[HI_W-1:0]);
        if (wr_en) begin
            if (wr_hi) begin
                ent_d[wr_idx].hi  = wr_data[HI_W-1:0];
                ent_d[wr_idx].cmp = new_mac;
                ent_d[wr_idx].vld = wr_data[WORD_W-1] && (new_mac != '0);
            end else begin
                ent_d[wr_idx].lo  = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) ent_q[i] <= '0;
            ent_q[0].lo  <= mac_to_lo(STATION_ADDR);
            ent_q[0].hi  <= mac_to_hi(STATION_ADDR);
            ent_q[0].cmp <= STATION_ADDR;
            ent_q[0].vld <= (STATION_ADDR != '0);
        end else begin
            for (int i = 0; i < NUM_ENTRIES; i++) ent_q[i] <= ent_d[i];
        end
    end

    always_comb begin
        if (rd_hi) rd_data = {ent_q[rd_idx].vld, {RSV_W{1'b0}}, ent_q[rd_idx].hi};
        else       rd_data = ent_q[rd_idx].lo;
    end

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_out
        assign cmp_addr[g] = ent_q[g].cmp;
        assign cmp_vld[g]  = ent_q[g].vld;

        // R4
        nonzero_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_vld[g] |-> (cmp_addr[g] != '0));
    end

    // R5
    lo_write_keeps_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi) |=> ($stable(cmp_addr) && $stable(cmp_vld)));

endmodule

// File: rtl/raf_match.sv
module raf_match
    import raf_pkg::*;
#(
    parameter int  NUM_ENTRIES = 16,
    localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [MAC_W-1:0]                  da_addr,
    input  logic [NUM_ENTRIES-1:0][MAC_W-1:0] cmp_addr,
    input  logic [NUM_ENTRIES-1:0]            cmp_vld,
    output logic                              hit,
    output logic [IDX_W-1:0]                  idx
);

    logic [NUM_ENTRIES-1:0] eq;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign eq[g] = cmp_vld[g] && (cmp_addr[g] == da_addr);
    end

    // Scan downward so the lowest matching index is the last one assigned
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // R9
    hit_only_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (cmp_vld[idx] && (cmp_addr[idx] == da_addr)));

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import raf_pkg::*;
#(
    parameter int               NUM_ENTRIES  = 16,
    parameter logic [MAC_W-1:0] STATION_ADDR = 48'h02005E102030,
    localparam int              IDX_W        = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [IDX_W:0]    reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              da_valid,
    input  logic [47:0]       da_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_idx
);

    typedef struct packed {
        logic             vld;
        logic             hit;
        logic [IDX_W-1:0] idx;
    } res_t;

    res_t res_d, res_q;

    logic [NUM_ENTRIES-1:0][MAC_W-1:0] cmp_addr;
    logic [NUM_ENTRIES-1:0]            cmp_vld;
    logic                              m_hit;
    logic [IDX_W-1:0]                  m_idx;

    raf_entry_bank #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .STATION_ADDR(STATION_ADDR)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_idx  (reg_addr[IDX_W:1]),
        .wr_hi   (reg_addr[0]),
        .wr_data (reg_wdata),
        .rd_idx  (reg_addr[IDX_W:1]),
        .rd_hi   (reg_addr[0]),
        .rd_data (reg_rdata),
        .cmp_addr(cmp_addr),
        .cmp_vld (cmp_vld)
    );

    raf_match #(
        .NUM_ENTRIES(NUM_ENTRIES)
    ) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .da_addr (da_addr),
        .cmp_addr(cmp_addr),
        .cmp_vld (cmp_vld),
        .hit     (m_hit),
        .idx     (m_idx)
    );

    always_comb begin
        res_d     = '0;
        res_d.vld = da_valid;
        if (da_valid) begin
            res_d.hit = m_hit;
            res_d.idx = m_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.vld;
    assign res_hit   = res_q.hit;
    assign res_idx   = res_q.idx;

    // R6
    result_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid |=> res_valid);

    // R6
    no_result_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !da_valid |=> !res_valid);

    // R3
    reserved_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr[0] |-> (reg_rdata[30:16] == '0));

    // R7
    miss_index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_idx == '0));

endmodule

// File: tb/rx_addr_filter_bench.sv
`timescale 1ns/1ps
module rx_addr_filter_bench;

    localparam int          N       = 16;
    localparam int          IW      = $clog2(N);
    localparam logic [47:0] STATION = 48'h02005E102030;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_wr = 1'b0;
    logic [IW:0]    reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic           da_valid = 1'b0;
    logic [47:0]    da_addr = '0;
    logic           res_valid;
    logic           res_hit;
    logic [IW-1:0]  res_idx;

    int applied = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rx_addr_filter #(.NUM_ENTRIES(N), .STATION_ADDR(STATION)) u_rx_addr_filter (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .da_valid(da_valid),
        .da_addr(da_addr), .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx)
    );

    // Lookup table: {destination address, expected hit, expected index}
    localparam logic [52:0] LOOKUPS [7] = '{
        {48'h02005E102030, 1'b1, 4'd0},   // R7 station entry
        {48'hAABBCCDDEEFF, 1'b1, 4'd3},   // R8 entries 3 and 7 match, entry 1 disabled (R9)
        {48'h112233445566, 1'b1, 4'd9},   // R7
        {48'hFFEEDDCCBBAA, 1'b0, 4'd0},   // R10 reversed byte order
        {48'h000000000000, 1'b0, 4'd0},   // R9 empty entries
        {48'hAABBCCDDEEFE, 1'b0, 4'd0},   // R7 one bit off
        {48'h02005E102031, 1'b0, 4'd0}    // R7 one bit off station
    };

    function automatic logic [31:0] lo_of(input logic [47:0] m);
        return {m[23:16], m[31:24], m[39:32], m[47:40]};
    endfunction

    function automatic logic [31:0] hi_of(input logic [47:0] m, input logic flag);
        return {flag, 15'd0, m[7:0], m[15:8]};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic hi, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = {IW'(idx), hi};
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd_check(input string req, input int idx, input logic hi, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = {IW'(idx), hi};
        #1;
        check(req, {32'd0, reg_rdata}, {32'd0, exp});
    endtask

    task automatic lookup(input string req, input logic [47:0] a, input logic ehit, input logic [IW-1:0] eidx);
        @(negedge clk);
        da_addr  = a;
        da_valid = 1'b1;
        @(negedge clk);
        da_valid = 1'b0;
        check(req, {62'd0, res_valid, res_hit}, {62'd0, 1'b1, ehit});
        check(req, {60'd0, res_idx}, {60'd0, eidx});
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset contents
        rd_check("R1", 0, 1'b0, lo_of(STATION));
        rd_check("R1", 0, 1'b1, hi_of(STATION, 1'b1));
        rd_check("R1", 5, 1'b0, 32'd0);
        rd_check("R1", 5, 1'b1, 32'd0);
        @(negedge clk);
        check("R6", {63'd0, res_valid}, 64'd0);

        // Program the table
        wr(3, 1'b0, lo_of(48'hAABBCCDDEEFF));
        wr(3, 1'b1, hi_of(48'hAABBCCDDEEFF, 1'b1) | 32'h0123_0000);
        wr(7, 1'b0, lo_of(48'hAABBCCDDEEFF));
        wr(7, 1'b1, hi_of(48'hAABBCCDDEEFF, 1'b1));
        wr(1, 1'b0, lo_of(48'hAABBCCDDEEFF));
        wr(1, 1'b1, hi_of(48'hAABBCCDDEEFF, 1'b0));
        wr(9, 1'b0, lo_of(48'h112233445566));
        wr(9, 1'b1, hi_of(48'h112233445566, 1'b1));

        // R2 / R3 readback and reserved bits
        rd_check("R2", 3, 1'b0, 32'hDDCCBBAA);
        rd_check("R3", 3, 1'b1, 32'h8000FFEE);
        rd_check("R3", 1, 1'b1, 32'h0000FFEE);

        for (int i = 0; i < 7; i++) begin
            lookup("R7/R8/R9/R10 table", LOOKUPS[i][52:5], LOOKUPS[i][4], LOOKUPS[i][3:0]);
        end

        // R6 result is one cycle wide
        @(negedge clk);
        check("R6", {63'd0, res_valid}, 64'd0);

        // R5 lone low-word write does not alter matching
        wr(9, 1'b0, 32'd0);
        rd_check("R5", 9, 1'b0, 32'd0);
        lookup("R5", 48'h112233445566, 1'b1, 4'd9);
        lookup("R5", 48'h000000005566, 1'b0, 4'd0);
        wr(9, 1'b1, hi_of(48'h000000005566, 1'b1));
        lookup("R5", 48'h000000005566, 1'b1, 4'd9);
        lookup("R5", 48'h112233445566, 1'b0, 4'd0);

        // R4 all-zero address with flag set stays disabled
        wr(12, 1'b1, 32'h8000_0000);
        rd_check("R4", 12, 1'b1, 32'd0);
        lookup("R4", 48'h0, 1'b0, 4'd0);

        // R9 disabling entry 3 leaves entry 7 as the hit
        wr(3, 1'b1, hi_of(48'hAABBCCDDEEFF, 1'b0));
        lookup("R9", 48'hAABBCCDDEEFF, 1'b1, 4'd7);

        // R1 reset restores the table
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_check("R1", 9, 1'b0, 32'd0);
        lookup("R1", STATION, 1'b1, 4'd0);
        lookup("R1", 48'hAABBCCDDEEFF, 1'b0, 4'd0);

        summary();
    end

endmodule